// File: doc/BRIEF.md
# Serial Flash Read Command Responder

This block is the device side of a serial flash read path. A host drives chip select, serial clock and serial data in. The block decodes one of three read commands and streams bytes back on its serial output. One command reads a page of main memory. The other two read either of two page-sized SRAM buffers. Each command carries an 8-bit opcode and a 24-bit address, both MSB first. A set number of don't-care bytes follows the address, and then data is shifted out MSB first. The read address advances byte by byte and wraps inside the page or buffer being read. It never moves on to the next page or buffer.

All pins are sampled in the system clock domain. Input bits are taken on each rising edge of the serial clock, and output bits change on its falling edges. The stored content is a fixed pattern computed from the target, the page and the byte offset, so the model needs no storage arrays. The number of pages is a parameter. Deasserting chip select aborts any command at once and releases the output.

Top module: `sflash_read_resp`

## Requirements
- R1: After reset, and while chip select is high, the output enable `spi_miso_oe` is 0.
- R2: Opcodes 0x52 and 0xD2 start a main-memory page read. Address bits 23:11 select the page, taken modulo NUM_PAGES, and bits 10:0 give the first byte. The byte at offset f of page p reads as (f[7:0] + 0x35*f[10:8] + 0x03 + 8*p[4:0]) mod 256.
- R3: A page read waits for exactly four don't-care bytes after the address, and the output stays disabled during them. The first data bit is presented after the last don't-care byte.
- R4: A page read continues from byte 0 of the same page after byte 1055.
- R5: Opcodes 0x54 and 0xD4 read buffer 1, and 0x56 and 0xD6 read buffer 2. Each waits for one don't-care byte. Only address bits 10:0 are used, and the upper 13 bits have no effect on the data. The byte at offset f reads as (f[7:0] + 0x35*f[10:8] + T) mod 256, where T is 0xC1 for buffer 1 and 0x6B for buffer 2.
- R6: A buffer read continues from byte 0 after byte 1055.
- R7: A starting offset of 1056 or more is reduced by 1056 before reading.
- R8: Raising chip select disables the output within a few system clocks. The next falling edge of chip select restarts the bit count, even after an abort in the middle of a byte.
- R9: For an unrecognised opcode, the output stays disabled for every following serial clock until chip select rises.
- R10: Data bits leave MSB first and change only at falling serial-clock edges, so the output holds steady while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (0 = high impedance) |

## Verification
Page reads run with both page-read opcodes at low, high and near-end offsets. Data that lines up on the first returned byte shows that the don't-care count is right, and the bytes that cross the end of the page show that the read wraps inside the page. Buffer reads vary the ignored upper address bits and choose between the two buffers, which shows the buffers are told apart and the page field is ignored. Offsets above 1055, aborts in the middle of the opcode and in the middle of the data, and an unknown opcode followed by valid-looking bytes cover the offset reduction, the restart after an abort and the ignore state.

// File: rtl/sfr_pkg.sv
// Shared types and constants for the serial flash read responder.
// Assumes pages and buffers have one common size.
package sfr_pkg;
    localparam int PAGE_BYTES = 1056;
    localparam int OFF_W      = 11;
    localparam int PG_W       = 13;
    localparam int ADDR_BYTES = 3;
    localparam int DUMMY_W    = 3;

    typedef enum logic [1:0] {TGT_NONE, TGT_MAIN, TGT_BUF1, TGT_BUF2} tgt_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA, ST_IGNORE
    } st_e;
endpackage

// File: rtl/sfr_pin_sync.sv
// Brings the SPI pins into the clk domain and flags edges of SCK and CS.
// Assumes SCK is slower than clk / 4 and that MOSI holds steady around
// the rising edge of SCK. All three pins pass through the same number of
// stages, so they stay aligned.
module sfr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_high,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_sr, cs_sr, mosi_sr;
    logic              sck_d, cs_d;

    // Shift each pin through its synchroniser and keep the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sr  <= '0;
            cs_sr   <= '1;
            mosi_sr <= '0;
            sck_d   <= 1'b0;
            cs_d    <= 1'b1;
        end else begin
            sck_sr  <= {sck_sr[STAGES-2:0], sck_i};
            cs_sr   <= {cs_sr[STAGES-2:0], cs_n_i};
            mosi_sr <= {mosi_sr[STAGES-2:0], mosi_i};
            sck_d   <= sck_sr[STAGES-1];
            cs_d    <= cs_sr[STAGES-1];
        end
    end

    assign sck_rise = sck_sr[STAGES-1] & ~sck_d;
    assign sck_fall = ~sck_sr[STAGES-1] & sck_d;
    assign cs_fall  = ~cs_sr[STAGES-1] & cs_d;
    assign cs_high  = cs_sr[STAGES-1];
    assign mosi_s   = mosi_sr[STAGES-1];
endmodule

// File: rtl/sfr_opcode_dec.sv
// Maps an opcode byte to a read target and its don't-care byte count.
// Any other opcode gives valid = 0.
module sfr_opcode_dec
    import sfr_pkg::*;
#(
    parameter int MAIN_DUMMY = 4,
    parameter int BUF_DUMMY  = 1
) (
    input  logic [7:0]         opcode,
    output logic               valid,
    output tgt_e               tgt,
    output logic [DUMMY_W-1:0] dummy_n
);
    // Decode the opcode into a target and a wait count.
    always_comb begin
        valid   = 1'b1;
        tgt     = TGT_NONE;
        dummy_n = DUMMY_W'(BUF_DUMMY);
        unique case (opcode)
            8'h52, 8'hD2: begin tgt = TGT_MAIN; dummy_n = DUMMY_W'(MAIN_DUMMY); end
            8'h54, 8'hD4: tgt = TGT_BUF1;
            8'h56, 8'hD6: tgt = TGT_BUF2;
            default:      valid = 1'b0;
        endcase
    end

    // R3 R5: a valid opcode always names a target
    always_comb begin
        if (valid) begin
            dec_target_chk: assert (tgt != TGT_NONE);
        end
    end
endmodule

// File: rtl/sfr_byte_src.sv
// Gives the stored byte for a target, page and offset. The content is
// a fixed pattern, so the model needs no storage arrays.
// Assumes the offset is already below the page size.
module sfr_byte_src
    import sfr_pkg::*;
(
    input  tgt_e             tgt,
    input  logic [PG_W-1:0]  page,
    input  logic [OFF_W-1:0] off,
    output logic [7:0]       data
);
    logic [7:0] tag;

    // Pick the per-target offset term.
    always_comb begin
        case (tgt)
            TGT_MAIN: tag = 8'h03 + {page[4:0], 3'b000};
            TGT_BUF1: tag = 8'hC1;
            TGT_BUF2: tag = 8'h6B;
            default:  tag = 8'h00;
        endcase
    end

    assign data = off[7:0] + 8'(8'h35 * {5'd0, off[10:8]}) + tag;
endmodule

// File: rtl/sflash_read_resp.sv
// Serial flash read command responder. Decodes page-read and buffer-read
// commands from the SPI pins and streams data MSB first, wrapping inside
// the page or buffer being read. Assumes an SPI mode 0 host.
module sflash_read_resp
    import sfr_pkg::*;
#(
    parameter int NUM_PAGES   = 8192,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam logic [PG_W-1:0]  PAGE_MASK = PG_W'(NUM_PAGES - 1);
    localparam logic [OFF_W-1:0] LAST_OFF  = OFF_W'(PAGE_BYTES - 1);
    localparam logic [OFF_W-1:0] SIZE_OFF  = OFF_W'(PAGE_BYTES);

    logic sck_rise, sck_fall, cs_fall, cs_high, mosi_s;

    sfr_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n),
        .mosi_i(spi_mosi), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_fall(cs_fall), .cs_high(cs_high), .mosi_s(mosi_s)
    );

    st_e                state_q;
    tgt_e               tgt_q;
    logic [2:0]         bit_q;
    logic [6:0]         in_sr_q;
    logic [DUMMY_W-1:0] cnt_q, dummy_q;
    logic [15:0]        addr_q;
    logic [PG_W-1:0]    page_q;
    logic [OFF_W-1:0]   off_q;
    logic [7:0]         out_sr_q;
    logic [2:0]         obit_q;
    logic               so_q, oe_q;

    wire  [7:0]         rx_byte   = {in_sr_q, mosi_s};
    wire                byte_done = sck_rise && (bit_q == 3'd7);
    wire  [23:0]        full_addr = {addr_q, rx_byte};
    wire  [OFF_W-1:0]   raw_off   = full_addr[OFF_W-1:0];
    wire  [OFF_W-1:0]   start_off = (raw_off >= SIZE_OFF) ? raw_off - SIZE_OFF : raw_off;
    wire  [OFF_W-1:0]   next_off  = (off_q == LAST_OFF) ? '0 : off_q + 1'b1;

    logic               dec_valid;
    tgt_e               dec_tgt;
    logic [DUMMY_W-1:0] dec_dummy;
    logic [7:0]         cur_byte;

    sfr_opcode_dec dec_i (
        .opcode(rx_byte), .valid(dec_valid), .tgt(dec_tgt), .dummy_n(dec_dummy)
    );

    sfr_byte_src src_i (
        .tgt(tgt_q), .page(page_q), .off(off_q), .data(cur_byte)
    );

    // Command sequencer: collects input bytes and walks the phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tgt_q    <= TGT_NONE;
            bit_q    <= '0;
            in_sr_q  <= '0;
            cnt_q    <= '0;
            dummy_q  <= '0;
            addr_q   <= '0;
            page_q   <= '0;
            off_q    <= '0;
            out_sr_q <= '0;
            obit_q   <= '0;
            so_q     <= 1'b0;
            oe_q     <= 1'b0;
        end else if (cs_high) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
        end else if (cs_fall) begin
            state_q <= ST_OPC;
            bit_q   <= '0;
            cnt_q   <= '0;
            obit_q  <= '0;
        end else if (sck_rise) begin
            bit_q   <= bit_q + 1'b1;
            in_sr_q <= rx_byte[6:0];
            if (byte_done) begin
                case (state_q)
                    ST_OPC: begin
                        state_q <= dec_valid ? ST_ADDR : ST_IGNORE;
                        tgt_q   <= dec_tgt;
                        dummy_q <= dec_dummy;
                        cnt_q   <= '0;
                    end
                    ST_ADDR: begin
                        addr_q <= full_addr[15:0];
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == DUMMY_W'(ADDR_BYTES - 1)) begin
                            state_q <= ST_DUMMY;
                            cnt_q   <= '0;
                            page_q  <= full_addr[23:OFF_W] & PAGE_MASK;
                            off_q   <= start_off;
                        end
                    end
                    ST_DUMMY: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == dummy_q - 1'b1) begin
                            state_q <= ST_DATA;
                            obit_q  <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (sck_fall && state_q == ST_DATA) begin
            oe_q   <= 1'b1;
            obit_q <= obit_q + 1'b1;
            if (obit_q == 3'd0) begin
                so_q     <= cur_byte[7];
                out_sr_q <= {cur_byte[6:0], 1'b0};
                off_q    <= next_off;
            end else begin
                so_q     <= out_sr_q[7];
                out_sr_q <= {out_sr_q[6:0], 1'b0};
            end
        end
    end

    assign spi_miso    = so_q;
    assign spi_miso_oe = oe_q;

    // R8
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_high |=> !oe_q);
    // R9
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !oe_q);
    // R10
    so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(so_q));
    // R4 R6 R7
    off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= LAST_OFF);
    // R1
    idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && $past(state_q == ST_IDLE) |-> !oe_q);
endmodule

// File: tb/sflash_read_resp_tb_top.sv
module sflash_read_resp_tb_top;
    localparam int NUM_PAGES = 8192;
    localparam int HALF      = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe;
    int   n_chk = 0, n_bad = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    sflash_read_resp #(.NUM_PAGES(NUM_PAGES)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    function automatic logic [7:0] exp_byte(input int tgt, input int page, input int off);
        logic [7:0] t;
        logic [10:0] f = 11'(off);
        if (tgt == 0) t = 8'h03 + 8'(8 * (page % NUM_PAGES % 32));
        else if (tgt == 1) t = 8'hC1;
        else t = 8'h6B;
        return f[7:0] + 8'(8'h35 * f[10:8]) + t;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Shift nbits of tx out MSB first and collect what comes back.
    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx,
                        output bit oe_all, output bit oe_any, output bit steady);
        rx = '0; oe_all = 1; oe_any = 0; steady = 1;
        for (int i = 0; i < nbits; i++) begin
            logic b;
            mosi = tx[7 - i];
            repeat (HALF) @(negedge clk);
            b = miso;
            rx = {rx[6:0], b};
            oe_all &= miso_oe;
            oe_any |= miso_oe;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            if (miso_oe && miso !== b) steady = 0;
            sck = 1'b0;
        end
    endtask

    task automatic cs_start();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_end(input string req);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(miso_oe == 1'b0, req, miso_oe, 0);
    endtask

    // Send an opcode and address, wait, then compare n data bytes.
    task automatic run_read(input logic [7:0] op, input int tgt, input logic [23:0] addr,
                            input int ndum, input int n, input string req);
        logic [7:0] rx;
        bit oa, on, st, any_d;
        int page = int'(addr[23:11]);
        int off  = int'(addr[10:0]);
        if (off >= 1056) off -= 1056;
        cs_start();
        xfer(op, 8, rx, oa, on, st);
        for (int k = 2; k >= 0; k--) xfer(addr[8*k +: 8], 8, rx, oa, on, st);
        any_d = 0;
        for (int k = 0; k < ndum; k++) begin
            xfer(8'h00, 8, rx, oa, on, st);
            any_d |= on;
        end
        chk(!any_d, {req, " R3 dummy quiet"}, any_d, 0);
        for (int k = 0; k < n; k++) begin
            logic [7:0] e = exp_byte(tgt, page, off);
            xfer(8'h00, 8, rx, oa, on, st);
            chk(oa && rx == e, req, rx, e);
            chk(st, "R10 steady while SCK high", 0, 1);
            off = (off == 1055) ? 0 : off + 1;
        end
        cs_end("R8 release");
    endtask

    task automatic t_reset();
        chk(miso_oe == 1'b0, "R1 reset", miso_oe, 0);
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        bit oa, on, st;
        cs_start();
        xfer(8'h52, 3, rx, oa, on, st);
        cs_end("R8 abort in opcode");
        run_read(8'h54, 1, {13'h0, 11'd40}, 1, 2, "R8 restart after opcode abort");
        cs_start();
        xfer(8'hD6, 8, rx, oa, on, st);
        for (int k = 0; k < 4; k++) xfer(8'h00, 8, rx, oa, on, st);
        xfer(8'h00, 5, rx, oa, on, st);
        chk(on, "R8 data was driving", on, 1);
        cs_end("R8 abort in data");
        run_read(8'hD2, 0, {13'd9, 11'd77}, 4, 2, "R8 restart after data abort");
    endtask

    task automatic t_bad_op();
        logic [7:0] rx;
        bit oa, on, st, any;
        any = 0;
        cs_start();
        xfer(8'h0B, 8, rx, oa, on, st);
        any |= on;
        for (int k = 0; k < 6; k++) begin
            xfer(k[0] ? 8'h52 : 8'h00, 8, rx, oa, on, st);
            any |= on;
        end
        chk(!any, "R9 unknown opcode ignored", any, 0);
        cs_end("R9 release");
        run_read(8'h56, 2, {13'h0, 11'd5}, 1, 2, "R9 recovery");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        run_read(8'h52, 0, {13'd5, 11'd0}, 4, 4, "R2 page read 52");
        run_read(8'hD2, 0, {13'd8191, 11'd300}, 4, 3, "R2 page read D2");
        run_read(8'h52, 0, {13'd17, 11'd1053}, 4, 5, "R4 page wrap");
        run_read(8'h54, 1, {13'h1ABC, 11'd10}, 1, 3, "R5 buffer 1 upper ignored");
        run_read(8'hD4, 1, {13'h0001, 11'd600}, 1, 3, "R5 buffer 1 D4");
        run_read(8'hD6, 2, {13'h0000, 11'd600}, 1, 3, "R5 buffer 2 D6");
        run_read(8'h56, 2, {13'h1FFF, 11'd1054}, 1, 4, "R6 buffer wrap");
        run_read(8'h52, 0, {13'd3, 11'd1500}, 4, 3, "R7 page offset reduce");
        run_read(8'h54, 1, {13'd0, 11'd2047}, 1, 2, "R7 buffer offset reduce");
        t_abort();
        t_bad_op();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule